// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit processor core. Seventeen peripheral pending lines come in, each already the OR of that peripheral's own flags. Each source is gated by its own enable bit and by one global enable. A priority bit places each source in either the high or the low level. At every instruction boundary the controller picks one winner. It then holds a request strobe and a code address towards the core until the core acknowledges.

Source n jumps to 3 + 8·n. Reset leaves the address output at zero, which is the restart location, and no maskable request can take priority over reset. Two in-service flags record which levels are being serviced. A high-level request can interrupt a low-level handler. Nothing can interrupt a high-level handler. A return pulse from the core closes the highest open level. On acknowledge, the four lowest sources get a one-cycle clear pulse on their pending flag. Every other source must be cleared by its own software.

The enable and priority inputs come in three groups, sized 7, 8 and 2 bits. Sources 0–6 use bits 0–6 of group A, sources 7–14 use bits 0–7 of group B, and sources 15–16 use bits 0–1 of group C.

Top module: `vic_top`

## Requirements
- R1: While reset is high, and in the cycle after it falls, irq_req, hw_clr, svc_lo and svc_hi are 0 and irq_vec is 0x0000.
- R2: Granting source n drives irq_vec to 0x0003 + 8·n (for example 0x0013 for source 2 and 0x0083 for source 16).
- R3: Among eligible sources of the same level, the lowest source index wins.
- R4: Source s is eligible only when its enable bit is set: bit s of en_a for s<7, bit s-7 of en_b for 7≤s<15, bit s-15 of en_c for s≥15.
- R5: A source whose priority bit is 1 (same bit mapping as R4) is high level. Any eligible high-level source wins over every low-level source, whatever its index.
- R6: When ack is sampled high while irq_req is high, hw_clr goes high for exactly the next cycle. Only the bit of the granted source is set, and only if that source is 0..3. For any other source hw_clr stays all zero.
- R7: When svc_hi is 1, no grant is made. When only svc_lo is 1, only high-level sources may be granted.
- R8: On ack, svc_lo or svc_hi (by granted level) sets in the next cycle. A reti pulse clears svc_hi if it is set, otherwise svc_lo.
- R9: With gie at 0, no grant is made regardless of pending, enable and priority inputs.
- R10: Arbitration happens only on a cycle with boundary high and irq_req low. irq_req rises in the next cycle and holds, with irq_vec unchanged, until ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend | input | 17 | Pending line per source |
| en_a | input | 7 | Enable bits, sources 0–6 |
| en_b | input | 8 | Enable bits, sources 7–14 |
| en_c | input | 2 | Enable bits, sources 15–16 |
| pr_a | input | 7 | Priority bits, sources 0–6 (1 = high) |
| pr_b | input | 8 | Priority bits, sources 7–14 |
| pr_c | input | 2 | Priority bits, sources 15–16 |
| gie | input | 1 | Global enable for all maskable sources |
| boundary | input | 1 | Instruction boundary strobe |
| ack | input | 1 | Core accepts the pending vector |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Vector request to the core |
| irq_vec | output | 16 | Code address of the granted source |
| hw_clr | output | 17 | One-cycle flag clear pulse per source |
| svc_lo | output | 1 | Low level in service |
| svc_hi | output | 1 | High level in service |

## Verification
The bench raises several same-level sources together. If the index order were inverted or its scan broken, a different address would come out. It opens a low-level handler and then raises a high-level source, which must preempt; a same-level source must wait, and a design without nesting checks would grant it at once. A source with index 4 or higher is acknowledged next to ones in 0..3, so a design that cleared too wide or too narrow a range would show a wrong hw_clr pattern. Enable bits at group edges and the global enable are switched off one by one, and the pending inputs are changed while a request is held, so both a wrong mapping and a design that re-arbitrated before ack would be visible.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned NSRC  = 17;
  localparam int unsigned IDX_W = 5;
  localparam int unsigned VEC_W = 16;
  localparam int unsigned GRP_A = 7;
  localparam int unsigned GRP_B = 8;
  localparam int unsigned GRP_C = NSRC - GRP_A - GRP_B;
  localparam logic [NSRC-1:0] HW_MASK = NSRC'(4'hF);

  typedef enum logic {LVL_LO = 1'b0, LVL_HI = 1'b1} lvl_e;

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    return VEC_W'(3) + (VEC_W'(idx) << 3);
  endfunction
endpackage

// File: rtl/vic_map.sv
module vic_map #(
  parameter int unsigned N  = vic_pkg::NSRC,
  parameter int unsigned GA = vic_pkg::GRP_A,
  parameter int unsigned GB = vic_pkg::GRP_B,
  localparam int unsigned GC = N - GA - GB
) (
  input  logic [GA-1:0] grp_a,
  input  logic [GB-1:0] grp_b,
  input  logic [GC-1:0] grp_c,
  output logic [N-1:0]  flat
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i < GA) begin : g_a
      assign flat[i] = grp_a[i];
    end else if (i < GA + GB) begin : g_b
      assign flat[i] = grp_b[i-GA];
    end else begin : g_c
      assign flat[i] = grp_c[i-GA-GB];
    end
  end
endmodule

// File: rtl/vic_pick.sv
module vic_pick #(
  parameter int unsigned N = vic_pkg::NSRC,
  parameter int unsigned W = vic_pkg::IDX_W
) (
  input  logic [N-1:0] cand,
  output logic         hit,
  output logic [W-1:0] idx
);
  logic [N:0]   seen;
  logic [N-1:0] first;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_scan
    assign first[i]  = cand[i] & ~seen[i];
    assign seen[i+1] = seen[i] | cand[i];
  end
  assign hit = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (first[i]) idx = idx | W'(i);
    end
  end
endmodule

// File: rtl/vic_nest.sv
module vic_nest (
  input  logic clk,
  input  logic rst,
  input  logic set_lo,
  input  logic set_hi,
  input  logic reti,
  output logic svc_lo,
  output logic svc_hi
);
  logic lo_n, hi_n;

  always_comb begin
    lo_n = svc_lo;
    hi_n = svc_hi;
    if (reti) begin
      if (svc_hi) hi_n = 1'b0;
      else        lo_n = 1'b0;
    end
    if (set_lo) lo_n = 1'b1;
    if (set_hi) hi_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      svc_lo <= 1'b0;
      svc_hi <= 1'b0;
    end else begin
      svc_lo <= lo_n;
      svc_hi <= hi_n;
    end
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int unsigned N  = NSRC,
  parameter int unsigned IW = IDX_W,
  parameter int unsigned VW = VEC_W,
  parameter int unsigned GA = GRP_A,
  parameter int unsigned GB = GRP_B,
  parameter logic [N-1:0] HWC = HW_MASK,
  localparam int unsigned GC = N - GA - GB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  pend,
  input  logic [GA-1:0] en_a,
  input  logic [GB-1:0] en_b,
  input  logic [GC-1:0] en_c,
  input  logic [GA-1:0] pr_a,
  input  logic [GB-1:0] pr_b,
  input  logic [GC-1:0] pr_c,
  input  logic          gie,
  input  logic          boundary,
  input  logic          ack,
  input  logic          reti,
  output logic          irq_req,
  output logic [VW-1:0] irq_vec,
  output logic [N-1:0]  hw_clr,
  output logic          svc_lo,
  output logic          svc_hi
);
  logic [N-1:0]  en_flat, pr_flat, elig, cand_hi, cand_lo;
  logic          hit_hi, hit_lo, take, accept;
  logic [IW-1:0] idx_hi, idx_lo, win_idx, cur_idx;
  lvl_e          win_lvl, cur_lvl;

  vic_map #(.N(N), .GA(GA), .GB(GB)) u_map_en (
    .grp_a(en_a), .grp_b(en_b), .grp_c(en_c), .flat(en_flat));
  vic_map #(.N(N), .GA(GA), .GB(GB)) u_map_pr (
    .grp_a(pr_a), .grp_b(pr_b), .grp_c(pr_c), .flat(pr_flat));

  assign elig    = pend & en_flat & {N{gie}};
  assign cand_hi = elig & pr_flat;
  assign cand_lo = elig & ~pr_flat;

  vic_pick #(.N(N), .W(IW)) u_pick_hi (.cand(cand_hi), .hit(hit_hi), .idx(idx_hi));
  vic_pick #(.N(N), .W(IW)) u_pick_lo (.cand(cand_lo), .hit(hit_lo), .idx(idx_lo));

  always_comb begin
    take    = 1'b0;
    win_idx = idx_lo;
    win_lvl = LVL_LO;
    if (boundary && !irq_req && !svc_hi) begin
      if (hit_hi) begin
        take    = 1'b1;
        win_idx = idx_hi;
        win_lvl = LVL_HI;
      end else if (hit_lo && !svc_lo) begin
        take = 1'b1;
      end
    end
  end

  assign accept = ack && irq_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      cur_idx <= '0;
      cur_lvl <= LVL_LO;
      hw_clr  <= '0;
    end else begin
      hw_clr <= '0;
      if (accept) begin
        irq_req <= 1'b0;
        hw_clr  <= (N'(1) << cur_idx) & HWC;
      end else if (take) begin
        irq_req <= 1'b1;
        irq_vec <= vec_of(win_idx);
        cur_idx <= win_idx;
        cur_lvl <= win_lvl;
      end
    end
  end

  vic_nest u_nest (
    .clk(clk), .rst(rst),
    .set_lo(accept && cur_lvl == LVL_LO),
    .set_hi(accept && cur_lvl == LVL_HI),
    .reti(reti),
    .svc_lo(svc_lo), .svc_hi(svc_hi));
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int unsigned N  = vic_pkg::NSRC,
  parameter int unsigned VW = vic_pkg::VEC_W
) (
  input logic          clk,
  input logic          rst,
  input logic          gie,
  input logic          ack,
  input logic          irq_req,
  input logic [VW-1:0] irq_vec,
  input logic [N-1:0]  hw_clr,
  input logic          svc_hi
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !ack) |=> (irq_req && $stable(irq_vec))); // R10
  AST_VEC_ALIGN: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec[2:0] == 3'd3)); // R2
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hw_clr)); // R6
  AST_CLR_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    (|hw_clr) |-> $past(ack && irq_req)); // R6
  AST_NO_GRANT_IN_HI: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> !$past(svc_hi)); // R7
  AST_GIE_GATES: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(gie)); // R9
  AST_HI_FROM_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(svc_hi) |-> $past(ack && irq_req)); // R8
endmodule

bind vic_top vic_checker #(.N(N), .VW(VW)) u_chk (
  .clk(clk), .rst(rst), .gie(gie), .ack(ack), .irq_req(irq_req),
  .irq_vec(irq_vec), .hw_clr(hw_clr), .svc_hi(svc_hi));

// File: tb/vic_top_bench.sv
module vic_top_bench;
  localparam int N = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] pend = '0;
  logic [6:0] en_a = '1, pr_a = '0;
  logic [7:0] en_b = '1, pr_b = '0;
  logic [1:0] en_c = '1, pr_c = '0;
  logic gie = 1'b1, boundary = 1'b0, ack = 1'b0, reti = 1'b0;
  logic irq_req, svc_lo, svc_hi;
  logic [15:0] irq_vec;
  logic [N-1:0] hw_clr;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vic_top u_vic_top (
    .clk(clk), .rst(rst), .pend(pend), .en_a(en_a), .en_b(en_b), .en_c(en_c),
    .pr_a(pr_a), .pr_b(pr_b), .pr_c(pr_c), .gie(gie), .boundary(boundary),
    .ack(ack), .reti(reti), .irq_req(irq_req), .irq_vec(irq_vec),
    .hw_clr(hw_clr), .svc_lo(svc_lo), .svc_hi(svc_hi));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic arb();
    boundary = 1'b1; tick(); boundary = 1'b0;
  endtask
  task automatic take_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask
  task automatic ret();
    reti = 1'b1; tick(); reti = 1'b0;
  endtask
  function automatic logic [15:0] v(int n);
    return 16'(3 + 8 * n);
  endfunction

  task automatic t_reset();
    chk("R1 req", 32'(irq_req), 0);
    chk("R1 vec", 32'(irq_vec), 0);
    chk("R1 clr", 32'(hw_clr), 0);
    chk("R1 svc", {30'd0, svc_hi, svc_lo}, 0);
  endtask

  task automatic t_same_level();
    pend = '0; pend[9] = 1; pend[4] = 1; pend[2] = 1;
    arb();
    chk("R3 req", 32'(irq_req), 1);
    chk("R3 vec src2", 32'(irq_vec), 32'(v(2)));
    take_ack();
    chk("R6 clr src2", 32'(hw_clr), 32'h4);
    chk("R8 svc_lo set", {30'd0, svc_hi, svc_lo}, 1);
    tick();
    chk("R6 pulse one cycle", 32'(hw_clr), 0);
    pend = '0;
    ret();
    chk("R8 reti lo", {30'd0, svc_hi, svc_lo}, 0);
  endtask

  task automatic t_hold();
    pend = '0; pend[5] = 1;
    arb();
    chk("R2 vec src5", 32'(irq_vec), 32'h2B);
    pend[0] = 1;
    arb();
    tick();
    chk("R10 req held", 32'(irq_req), 1);
    chk("R10 vec held", 32'(irq_vec), 32'h2B);
    take_ack();
    chk("R6 no clr src5", 32'(hw_clr), 0);
    pend = '0;
    ret();
  endtask

  task automatic t_preempt();
    pr_b = 8'h08; // source 10 high
    pend = '0; pend[1] = 1;
    arb();
    chk("R2 vec src1", 32'(irq_vec), 32'h0B);
    take_ack();
    chk("R6 clr src1", 32'(hw_clr), 32'h2);
    pend[10] = 1;
    arb();
    chk("R7 preempt req", 32'(irq_req), 1);
    chk("R7 preempt vec", 32'(irq_vec), 32'h53);
    take_ack();
    chk("R8 both svc", {30'd0, svc_hi, svc_lo}, 3);
    arb();
    chk("R7 none in hi", 32'(irq_req), 0);
    ret();
    chk("R8 reti hi first", {30'd0, svc_hi, svc_lo}, 1);
    pend[10] = 0;
    arb();
    chk("R7 lo waits", 32'(irq_req), 0);
    ret();
    chk("R8 reti lo after", {30'd0, svc_hi, svc_lo}, 0);
    pend = '0; pend[0] = 1; pend[10] = 1;
    arb();
    chk("R5 hi beats idx0", 32'(irq_vec), 32'h53);
    take_ack();
    chk("R6 no clr src10", 32'(hw_clr), 0);
    pend = '0;
    ret();
    pr_b = '0;
  endtask

  task automatic t_mask();
    pend = '0; pend[3] = 1;
    en_a[3] = 0;
    arb();
    chk("R4 en_a bit3 off", 32'(irq_req), 0);
    en_a[3] = 1; gie = 0;
    arb();
    chk("R9 gie off", 32'(irq_req), 0);
    gie = 1;
    arb();
    chk("R9 gie on vec", 32'(irq_vec), 32'h1B);
    take_ack();
    chk("R6 clr src3", 32'(hw_clr), 32'h8);
    pend = '0;
    ret();
    pend[15] = 1; pend[16] = 1; en_c = 2'b10;
    arb();
    chk("R4 en_c map vec", 32'(irq_vec), 32'(v(16)));
    take_ack();
    chk("R6 no clr src16", 32'(hw_clr), 0);
    pend = '0;
    ret();
    en_c = '1;
    pend[7] = 1; en_b[0] = 0;
    arb();
    chk("R4 en_b bit0 off", 32'(irq_req), 0);
    en_b[0] = 1; pend = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    t_reset();
    rst = 1'b0;
    tick();
    t_reset();
    t_same_level();
    t_hold();
    t_preempt();
    t_mask();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule